// File: doc/BRIEF.md
# Two-Channel Fixed-Rate Pulse Generator

This block produces two pulse-width-modulated outputs. Each channel is clocked by tick pulses from its own external numerically controlled oscillator (NCO). A channel counts those ticks through a repeating cycle whose length is set by an 8-bit period value. During each cycle the output is high for a programmable number of ticks. Each channel also stores a 16-bit frequency word, which it hands to its external NCO.

Software controls the block through a word-addressed register port. Writes take effect on a clock edge, and reads are combinational. A shared control word holds four bits per channel: run, output-enable (active low), force-high and open-drain. A second control word picks, for each channel, either the modulated signal or the raw NCO signal. Each pad is modelled as an output-enable and a data output.

On-time and period values written while a channel runs are held back until the current cycle ends. This means a pulse is never cut short or stretched.

Top module: `pwm_pair`

## Requirements
- R1: After reset, word 0 reads 0x22 (both output-enable-low bits set) and every other register reads 0. With output-enable-low set, both pads report pad_oe = 0.
- R2: The word addresses are:
  - 0: control
  - 1: select
  - 2+2n: frequency high byte of channel n
  - 3+2n: frequency low byte of channel n
  - 6+2n: on-time of channel n
  - 7+2n: period of channel n

  Reads return the stored values, with unwritten bits as 0. Control keeps bits 7:0, select keeps bits 0 and 4, and the byte registers keep bits 7:0. Every other address reads 0. nco_word[16n+15:16n] equals {high byte, low byte} of channel n.
- R3: While control bit 4n (run) is set, the channel counter advances by one on each tick and wraps to 0 after reaching the active period. One cycle therefore lasts period+1 ticks.
- R4: With select bit 4n set, the channel level is high while the counter is below the active on-time. It is low otherwise.
- R5: An on-time greater than the period gives a level that stays high.
- R6: While the run bit is clear, the counter stays at 0 and the modulated level is low.
- R7: Newly written on-time and period values become active at the tick that wraps the counter. While the channel is stopped, they become active one clock after the write.
- R8: With select bit 4n clear, the level follows nco_sig[n].
- R9: Control bit 4n+2 (force high) makes the level 1, whatever the counter or select state.
- R10: Control bit 4n+1 (output-enable low) forces pad_oe[n] to 0.
- R11: With control bit 4n+3 (open drain) set, pad_do[n] is 0 and the pad is enabled only while the level is 0. Otherwise pad_oe[n] is 1 and pad_do[n] equals the level. R10 takes priority over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| nco_tick | input | 2 | One-clock tick per channel from its NCO |
| nco_sig | input | 2 | Raw NCO signal per channel |
| nco_word | output | 32 | Frequency word per channel for the external NCO |
| pad_oe | output | 2 | Pad output enable per channel |
| pad_do | output | 2 | Pad data per channel |

## Verification
The bench builds the block with its default package values: two channels, 8-bit counters and a 4-bit word address. It uses different tick rates on the two channels, so their cycles drift against each other. With the full 8-bit range, the bench can exercise a period of 0 (one-tick cycles) and a period of 255 (256-tick cycles). The same range lets it test an on-time of 255 against a period of 254, and values rewritten mid-cycle that must wait for the wrap.

// File: rtl/pwm_pair_pkg.sv
`timescale 1ns/1ps
package pwm_pair_pkg;
    localparam int NCH        = 2;
    localparam int CH_SPACING = 4;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = BYTE_W;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;

    // control bit positions inside a channel's nibble
    localparam int B_RUN   = 0;
    localparam int B_OEN   = 1;
    localparam int B_FORCE = 2;
    localparam int B_OD    = 3;
    localparam int B_SEL   = 0;

    localparam int A_CTRL      = 0;
    localparam int A_SEL       = 1;
    localparam int A_FREQ_BASE = 2;
    localparam int A_DUTY_BASE = 6;
    localparam int A_STRIDE    = 2;

    typedef struct packed {
        logic             run;
        logic             oe_n;
        logic             force_hi;
        logic             open_drain;
        logic             sel_pwm;
        logic [CNT_W-1:0] on_t;
        logic [CNT_W-1:0] period;
    } chan_cfg_t;

    function automatic int freq_hi_addr(int n);
        return A_FREQ_BASE + A_STRIDE * n;
    endfunction
    function automatic int freq_lo_addr(int n);
        return A_FREQ_BASE + A_STRIDE * n + 1;
    endfunction
    function automatic int on_addr(int n);
        return A_DUTY_BASE + A_STRIDE * n;
    endfunction
    function automatic int per_addr(int n);
        return A_DUTY_BASE + A_STRIDE * n + 1;
    endfunction

    function automatic logic [NCH*CH_SPACING-1:0] ctrl_reset();
        logic [NCH*CH_SPACING-1:0] v;
        v = '0;
        for (int n = 0; n < NCH; n++) v[n*CH_SPACING+B_OEN] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/pwm_pair_regs.sv
`timescale 1ns/1ps
module pwm_pair_regs
    import pwm_pair_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output chan_cfg_t [NCH-1:0]          cfg,
    output logic [NCH*WORD_W-1:0]        nco_word
);
    localparam int CTRL_W = NCH * CH_SPACING;

    logic [CTRL_W-1:0]             ctrl_q;
    logic [NCH-1:0]                sel_q;
    logic [NCH-1:0][BYTE_W-1:0]    hi_q, lo_q, on_q, per_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_reset();
            sel_q  <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            on_q   <= '0;
            per_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
            for (int n = 0; n < NCH; n++) begin
                if (addr == ADDR_W'(A_SEL))           sel_q[n] <= wdata[n*CH_SPACING+B_SEL];
                if (addr == ADDR_W'(freq_hi_addr(n))) hi_q[n]  <= wdata[BYTE_W-1:0];
                if (addr == ADDR_W'(freq_lo_addr(n))) lo_q[n]  <= wdata[BYTE_W-1:0];
                if (addr == ADDR_W'(on_addr(n)))      on_q[n]  <= wdata[BYTE_W-1:0];
                if (addr == ADDR_W'(per_addr(n)))     per_q[n] <= wdata[BYTE_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL)) rdata[CTRL_W-1:0] = ctrl_q;
        for (int n = 0; n < NCH; n++) begin
            if (addr == ADDR_W'(A_SEL))           rdata[n*CH_SPACING+B_SEL] = sel_q[n];
            if (addr == ADDR_W'(freq_hi_addr(n))) rdata[BYTE_W-1:0] = hi_q[n];
            if (addr == ADDR_W'(freq_lo_addr(n))) rdata[BYTE_W-1:0] = lo_q[n];
            if (addr == ADDR_W'(on_addr(n)))      rdata[BYTE_W-1:0] = on_q[n];
            if (addr == ADDR_W'(per_addr(n)))     rdata[BYTE_W-1:0] = per_q[n];
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_cfg
        assign cfg[n].run        = ctrl_q[n*CH_SPACING+B_RUN];
        assign cfg[n].oe_n       = ctrl_q[n*CH_SPACING+B_OEN];
        assign cfg[n].force_hi   = ctrl_q[n*CH_SPACING+B_FORCE];
        assign cfg[n].open_drain = ctrl_q[n*CH_SPACING+B_OD];
        assign cfg[n].sel_pwm    = sel_q[n];
        assign cfg[n].on_t       = on_q[n];
        assign cfg[n].period     = per_q[n];
        assign nco_word[n*WORD_W +: WORD_W] = {hi_q[n], lo_q[n]};
    end
endmodule

// File: rtl/pwm_pair_chan.sv
`timescale 1ns/1ps
module pwm_pair_chan
    import pwm_pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chan_cfg_t        cfg,
    input  logic             tick,
    input  logic             nco_sig,
    output logic             level,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o
);
    logic [CNT_W-1:0] cnt_q, on_act_q, per_act_q;
    logic             pwm_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            on_act_q  <= '0;
            per_act_q <= '0;
        end else if (!cfg.run) begin
            cnt_q     <= '0;
            on_act_q  <= cfg.on_t;
            per_act_q <= cfg.period;
        end else if (tick) begin
            if (cnt_q == per_act_q) begin
                cnt_q     <= '0;
                on_act_q  <= cfg.on_t;
                per_act_q <= cfg.period;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pwm_raw = cfg.run && (cnt_q < on_act_q);
    assign level   = cfg.force_hi | (cfg.sel_pwm ? pwm_raw : nco_sig);
    assign cnt_o   = cnt_q;
    assign per_o   = per_act_q;
endmodule

// File: rtl/pwm_pair_pad.sv
`timescale 1ns/1ps
module pwm_pair_pad (
    input  logic level,
    input  logic oe_n,
    input  logic open_drain,
    output logic oe,
    output logic dout
);
    always_comb begin
        if (open_drain) begin
            dout = 1'b0;
            oe   = !oe_n && !level;
        end else begin
            dout = level;
            oe   = !oe_n;
        end
    end
endmodule

// File: rtl/pwm_pair.sv
`timescale 1ns/1ps
module pwm_pair
    import pwm_pair_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NCH-1:0]        nco_tick,
    input  logic [NCH-1:0]        nco_sig,
    output logic [NCH*WORD_W-1:0] nco_word,
    output logic [NCH-1:0]        pad_oe,
    output logic [NCH-1:0]        pad_do
);
    chan_cfg_t [NCH-1:0]           cfg;
    logic [NCH-1:0]                level;
    logic [NCH-1:0][CNT_W-1:0]     ch_cnt, ch_per;

    pwm_pair_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cfg      (cfg),
        .nco_word (nco_word)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pwm_pair_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg[n]),
            .tick    (nco_tick[n]),
            .nco_sig (nco_sig[n]),
            .level   (level[n]),
            .cnt_o   (ch_cnt[n]),
            .per_o   (ch_per[n])
        );
        pwm_pair_pad u_pad (
            .level      (level[n]),
            .oe_n       (cfg[n].oe_n),
            .open_drain (cfg[n].open_drain),
            .oe         (pad_oe[n]),
            .dout       (pad_do[n])
        );
    end
endmodule

// File: rtl/pwm_pair_chk.sv
`timescale 1ns/1ps
module pwm_pair_chk
    import pwm_pair_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input chan_cfg_t [NCH-1:0]       cfg,
    input logic [NCH-1:0]            tick,
    input logic [NCH-1:0][CNT_W-1:0] cnt,
    input logic [NCH-1:0][CNT_W-1:0] per,
    input logic [NCH-1:0]            pad_oe,
    input logic [NCH-1:0]            pad_do
);
    for (genvar n = 0; n < NCH; n++) begin : g_a
        AST_WRAP_AT_PERIOD: assert property (@(posedge clk) disable iff (rst)
            cfg[n].run && tick[n] && cnt[n] == per[n] |=> cnt[n] == '0); // R3
        AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
            cfg[n].run && tick[n] && cnt[n] != per[n] |=> cnt[n] == CNT_W'($past(cnt[n]) + 1)); // R3
        AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
            cfg[n].run && !tick[n] |=> $stable(cnt[n])); // R3
        AST_COUNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (rst)
            cfg[n].run |-> cnt[n] <= per[n]); // R3
        AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
            !cfg[n].run |=> cnt[n] == '0); // R6
        AST_FORCE_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
            cfg[n].force_hi && !cfg[n].oe_n && !cfg[n].open_drain |-> pad_oe[n] && pad_do[n]); // R9
        AST_OEN_RELEASES_PAD: assert property (@(posedge clk) disable iff (rst)
            cfg[n].oe_n |-> !pad_oe[n]); // R10
        AST_OD_NEVER_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
            cfg[n].open_drain |-> !pad_do[n]); // R11
    end
endmodule

bind pwm_pair pwm_pair_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg    (cfg),
    .tick   (nco_tick),
    .cnt    (ch_cnt),
    .per    (ch_per),
    .pad_oe (pad_oe),
    .pad_do (pad_do)
);

// File: tb/pwm_pair_tb_top.sv
`timescale 1ns/1ps
module pwm_pair_tb_top;
    import pwm_pair_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic                  reg_wr = 1'b0;
    logic [ADDR_W-1:0]     reg_addr = '0;
    logic [DATA_W-1:0]     reg_wdata = '0;
    logic [DATA_W-1:0]     reg_rdata;
    logic [NCH-1:0]        nco_tick = '0;
    logic [NCH-1:0]        nco_sig = '0;
    logic [NCH*WORD_W-1:0] nco_word;
    logic [NCH-1:0]        pad_oe, pad_do;

    pwm_pair dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nco_tick(nco_tick),
        .nco_sig(nco_sig), .nco_word(nco_word), .pad_oe(pad_oe), .pad_do(pad_do)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;

    // behavioural reference state
    logic [31:0] m_ctrl, m_sel;
    int m_hi[NCH], m_lo[NCH], m_on_r[NCH], m_per_r[NCH];
    int m_cnt[NCH], m_on_a[NCH], m_per_a[NCH];

    function automatic void check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic void model_write(int a, logic [31:0] d);
        if (a == 0) m_ctrl = d & 32'hFF;
        if (a == 1) m_sel  = d & 32'h11;
        for (int c = 0; c < NCH; c++) begin
            if (a == 2 + 2*c) m_hi[c]    = int'(d & 32'hFF);
            if (a == 3 + 2*c) m_lo[c]    = int'(d & 32'hFF);
            if (a == 6 + 2*c) m_on_r[c]  = int'(d & 32'hFF);
            if (a == 7 + 2*c) m_per_r[c] = int'(d & 32'hFF);
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 32'h22; m_sel = 0;
            for (int c = 0; c < NCH; c++) begin
                m_hi[c] = 0; m_lo[c] = 0; m_on_r[c] = 0; m_per_r[c] = 0;
                m_cnt[c] = 0; m_on_a[c] = 0; m_per_a[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (!m_ctrl[4*c]) begin
                    m_cnt[c] = 0; m_on_a[c] = m_on_r[c]; m_per_a[c] = m_per_r[c];
                end else if (nco_tick[c]) begin
                    if (m_cnt[c] == m_per_a[c]) begin
                        m_cnt[c] = 0; m_on_a[c] = m_on_r[c]; m_per_a[c] = m_per_r[c];
                    end else begin
                        m_cnt[c] = m_cnt[c] + 1;
                    end
                end
            end
            if (reg_wr) model_write(int'(reg_addr), reg_wdata);
        end
    end

    // per-clock comparison of both pads against the model
    always @(negedge clk) begin
        #1;
        if (cmp_en && !done) begin
            for (int c = 0; c < NCH; c++) begin
                bit lvl, e_oe, e_do;
                lvl = m_ctrl[4*c+2] ? 1'b1 :
                      (m_sel[4*c] ? (m_ctrl[4*c] && m_cnt[c] < m_on_a[c]) : nco_sig[c]);
                if (m_ctrl[4*c+3]) begin
                    e_do = 1'b0; e_oe = !m_ctrl[4*c+1] && !lvl;
                end else begin
                    e_do = lvl;  e_oe = !m_ctrl[4*c+1];
                end
                check(cur_req, $sformatf("ch%0d pad {oe,do}", c),
                      int'({pad_oe[c], pad_do[c]}), int'({e_oe, e_do}));
            end
        end
    end

    // NCO tick sources: channel 0 every 2 clocks, channel 1 every 3
    initial begin
        int k;
        k = 0;
        forever begin
            @(negedge clk);
            k++;
            nco_tick[0] = (k % 2 == 0);
            nco_tick[1] = (k % 3 == 0);
            nco_sig = nco_sig ^ nco_tick;
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, int exp, string req);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1;
        check(req, $sformatf("read addr %0d", a), int'(reg_rdata), exp);
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired during %s actual=running expected=finished", cur_req);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        rd(0, 32'h22, "R1");
        for (int a = 1; a < 10; a++) rd(a, 0, "R1");
        check("R1", "pad_oe after reset", int'(pad_oe), 0);
        check("R1", "nco_word after reset", int'(nco_word), 0);
        cmp_en = 1'b1;

        // R2: masks, map and frequency word
        cur_req = "R2";
        for (int a = 0; a < 16; a++) wr(a, 32'hFFFF_FFFF);
        rd(0, 32'hFF, "R2");
        rd(1, 32'h11, "R2");
        for (int a = 2; a < 10; a++) rd(a, 32'hFF, "R2");
        for (int a = 10; a < 16; a++) rd(a, 0, "R2");
        check("R2", "nco_word all ones", int'(nco_word), 32'hFFFF_FFFF);
        wr(0, 32'h22);
        wr(2, 32'h12); wr(3, 32'h34); wr(4, 32'h56); wr(5, 32'h78);
        check("R2", "nco_word packing", int'(nco_word), 32'h5678_1234);

        // R3/R4: counting and duty, period 0 on channel 1
        cur_req = "R3";
        wr(6, 2); wr(7, 4); wr(8, 1); wr(9, 0);
        wr(1, 32'h11); wr(0, 32'h11);
        run(60);
        cur_req = "R4";
        wr(6, 3); wr(7, 5); wr(8, 0); wr(9, 2);
        run(60);
        cur_req = "R3";
        wr(6, 128); wr(7, 255);
        run(1100);

        // R7: mid-cycle rewrite waits for the wrap
        cur_req = "R7";
        wr(6, 1); wr(7, 6);
        run(5);
        wr(6, 4); wr(7, 2);
        run(60);

        // R5: on-time above period
        cur_req = "R5";
        wr(6, 9); wr(7, 3); wr(8, 255); wr(9, 254);
        run(80);

        // R6: stopped
        cur_req = "R6";
        wr(0, 32'h00);
        run(30);

        // R8: raw NCO bypass
        cur_req = "R8";
        wr(6, 2); wr(7, 4); wr(8, 1); wr(9, 3);
        wr(0, 32'h11); wr(1, 32'h00);
        run(40);

        // R9: force high over pwm and bypass
        cur_req = "R9";
        wr(0, 32'h55);
        run(20);
        wr(1, 32'h11);
        run(20);

        // R10: output enable low
        cur_req = "R10";
        wr(0, 32'h33);
        run(20);

        // R11: open drain, then open drain with force and with enable low
        cur_req = "R11";
        wr(0, 32'h99);
        run(40);
        wr(0, 32'hDD);
        run(10);
        wr(0, 32'hBB);
        run(10);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule